// File: doc/BRIEF.md
# Bridge Deadlock Resolution Controller

This block sits between the two slave engines of a two-bus bridge: a slave on the processor bus and a slave on the PCI side, each feeding its own inbound FIFO. When both slaves are stalled waiting on each other, the bridge cannot make progress. The block watches the two stall flags. It declares a deadlock when both are raised in the same cycle. It then decides how the processor-side slave backs out, based on the kind of transaction that slave is serving.

Reads and non-posted writes are ended with a retry. For a read that spans a 4-byte boundary and has already moved some beats, the block also orders the partial data thrown away. A posted write is never interrupted. The block waits for that write's completion strobe and lets the stall clear by itself. With every retry, the block also decides whether the pending command is removed from the processor-side FIFO.

The boundary size is set by a parameter.

Top module: `lock_resolver`

## Requirements
- R1: A resolution starts only on a clock edge where both `host_stall` and `pci_stall` are high. Its outputs appear in the cycle after that edge. One stall flag alone never produces an output.
- R2: When a resolution starts with `xact_type` = 01 (read), `retry_req` is high for exactly one cycle.
- R3: When a resolution starts with `xact_type` = 11 (non-posted write), `retry_req` pulses for one cycle. `discard_rd_data` stays low, even when the write spans a boundary.
- R4: When a resolution starts with `xact_type` = 10 (posted write), no output is raised. No further resolution starts until a `wr_done` strobe has been sampled.
- R5: When a resolution starts with `xact_type` = 00 (idle), no output is raised.
- R6: `discard_rd_data` pulses together with the read retry exactly when the read spans a boundary and `part_done` is high. A read spans a boundary when `xact_off + xact_len > 2**ALIGN_W`, with `xact_off` as the byte offset and `xact_len` as the byte count.
- R7: `fifo_pop` pulses together with `retry_req` exactly when `cmd_pending` is high. It is never high without a retry.
- R8: After a resolution, no new one starts until a clock edge samples both stall flags low, and any posted-write wait has ended.
- R9: After reset, all outputs are low and the block is ready to detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stall | input | 1 | Processor-side slave is stalled |
| pci_stall | input | 1 | PCI-side slave is stalled |
| xact_type | input | 2 | Transaction on the processor side: 00 idle, 01 read, 10 posted write, 11 non-posted write |
| xact_off | input | ALIGN_W | Start byte offset within the aligned unit |
| xact_len | input | ALIGN_W+1 | Byte count of the transaction |
| part_done | input | 1 | Some read beats have already completed |
| cmd_pending | input | 1 | A command for this transaction waits in the processor-side FIFO |
| wr_done | input | 1 | Posted write completion strobe |
| retry_req | output | 1 | Terminate the processor-side cycle with retry |
| discard_rd_data | output | 1 | Drop the partially collected read data |
| fifo_pop | output | 1 | Remove the pending command from the processor-side FIFO |

## Verification
The bench builds the block with `ALIGN_W` = 2, which gives a 4-byte unit. It sweeps every start offset from 0 to 3 and every length from 1 to 4 for all four transaction types, with both settings of `part_done` and `cmd_pending`. This covers both the aligned case and every boundary-spanning case. Separate sequences hold the stall flags high across several edges, raise one flag alone, and raise the stalls again during a posted-write wait, to exercise re-arming.

// File: rtl/lock_resolver.sv
module lock_resolver #(
  parameter int ALIGN_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_stall,
  input  logic               pci_stall,
  input  logic [1:0]         xact_type,
  input  logic [ALIGN_W-1:0] xact_off,
  input  logic [ALIGN_W:0]   xact_len,
  input  logic               part_done,
  input  logic               cmd_pending,
  input  logic               wr_done,
  output logic               retry_req,
  output logic               discard_rd_data,
  output logic               fifo_pop
);
  localparam int SUM_W = ALIGN_W + 2;
  localparam logic [SUM_W-1:0] UNIT = SUM_W'(1 << ALIGN_W);

  logic armed, pw_wait;
  logic detect, is_rd, is_np, is_pw, spans, do_retry;
  logic [SUM_W-1:0] end_pos;

  assign end_pos  = SUM_W'(xact_off) + SUM_W'(xact_len);
  assign spans    = end_pos > UNIT;
  assign is_rd    = xact_type == 2'b01;
  assign is_pw    = xact_type == 2'b10;
  assign is_np    = xact_type == 2'b11;
  assign detect   = armed & ~pw_wait & host_stall & pci_stall;
  assign do_retry = detect & (is_rd | is_np);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed           <= 1'b1;
      pw_wait         <= 1'b0;
      retry_req       <= 1'b0;
      discard_rd_data <= 1'b0;
      fifo_pop        <= 1'b0;
    end else begin
      retry_req       <= do_retry;
      discard_rd_data <= detect & is_rd & spans & part_done;
      fifo_pop        <= do_retry & cmd_pending;
      if (detect) begin
        armed <= 1'b0;
        if (is_pw) pw_wait <= 1'b1;
      end else begin
        if (pw_wait && wr_done) pw_wait <= 1'b0;
        if (!armed && !pw_wait && !host_stall && !pci_stall) armed <= 1'b1;
      end
    end
  end
endmodule

module lock_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_stall,
  input logic       pci_stall,
  input logic [1:0] xact_type,
  input logic       retry_req,
  input logic       discard_rd_data,
  input logic       fifo_pop
);
  a_r1_both_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> $past(host_stall && pci_stall));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);
  a_r4_no_pw_retry: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> ($past(xact_type) != 2'b10 && $past(xact_type) != 2'b00));
  a_r6_discard_read: assert property (@(posedge clk) disable iff (!rst_n)
    discard_rd_data |-> (retry_req && $past(xact_type) == 2'b01));
  a_r7_pop_with_retry: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> retry_req);
endmodule

bind lock_resolver lock_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_stall(host_stall), .pci_stall(pci_stall),
  .xact_type(xact_type), .retry_req(retry_req),
  .discard_rd_data(discard_rd_data), .fifo_pop(fifo_pop)
);

// File: tb/tb_lock_resolver.sv
module tb_lock_resolver;
  localparam int AW = 2;
  logic clk = 0, rst_n = 0;
  logic host_stall = 0, pci_stall = 0, part_done = 0, cmd_pending = 0, wr_done = 0;
  logic [1:0] xact_type = 0;
  logic [AW-1:0] xact_off = 0;
  logic [AW:0] xact_len = 1;
  logic retry_req, discard_rd_data, fifo_pop;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lock_resolver #(.ALIGN_W(AW)) dut (.*);

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(string req);
    chk(req, retry_req, 1'b0);
    chk(req, discard_rd_data, 1'b0);
    chk(req, fifo_pop, 1'b0);
  endtask

  task automatic both_low();
    @(negedge clk); host_stall = 0; pci_stall = 0;
    @(posedge clk); #1;
  endtask

  task automatic resolve(int t, int off, int len, bit part, bit pend);
    bit rt, ds, pp, spans;
    spans = (off + len) > (1 << AW);
    rt = (t == 1) || (t == 3);
    ds = (t == 1) && spans && part;
    pp = rt && pend;
    @(negedge clk);
    xact_type = 2'(t); xact_off = AW'(off); xact_len = (AW+1)'(len);
    part_done = part; cmd_pending = pend; host_stall = 1; pci_stall = 1;
    @(posedge clk); #1;
    chk(t == 1 ? "R2" : t == 3 ? "R3" : t == 2 ? "R4" : "R5", retry_req, rt);
    chk(t == 3 ? "R3" : "R6", discard_rd_data, ds);
    chk("R7", fifo_pop, pp);
    both_low();
    chk("R2", retry_req, 1'b0);
    if (t == 2) begin
      @(negedge clk); host_stall = 1; pci_stall = 1;
      @(posedge clk); #1; chk_quiet("R4");
      @(negedge clk); host_stall = 0; pci_stall = 0; wr_done = 1;
      @(posedge clk); #1;
      @(negedge clk); wr_done = 0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; chk_quiet("R9");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1; chk_quiet("R9");

    @(negedge clk); xact_type = 2'b01; host_stall = 1;
    @(posedge clk); #1; chk("R1", retry_req, 1'b0);
    @(negedge clk); host_stall = 0; pci_stall = 1;
    @(posedge clk); #1; chk("R1", retry_req, 1'b0);
    @(negedge clk); host_stall = 1;
    @(posedge clk); #1; chk("R1", retry_req, 1'b1);
    @(posedge clk); #1; chk("R8", retry_req, 1'b0);
    @(posedge clk); #1; chk("R8", retry_req, 1'b0);
    @(negedge clk); pci_stall = 0;
    @(posedge clk); #1; chk("R8", retry_req, 1'b0);
    @(negedge clk); pci_stall = 1;
    @(posedge clk); #1; chk("R8", retry_req, 1'b0);
    both_low();
    @(negedge clk); host_stall = 1; pci_stall = 1;
    @(posedge clk); #1; chk("R8", retry_req, 1'b1);
    both_low();

    for (int t = 0; t < 4; t++)
      for (int off = 0; off < (1 << AW); off++)
        for (int len = 1; len <= (1 << AW); len++)
          for (int p = 0; p < 2; p++)
            for (int c = 0; c < 2; c++)
              resolve(t, off, len, p[0], c[0]);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule